// File: doc/BRIEF.md
# Banked Memory-Map Controller

This block sits beside an 8-bit CPU with a 16-bit address bus. For each access it decides which of eight external banks the address belongs to, and it works out the offset inside that bank. It also raises a write-inhibit when a write aims at a read-only bank.

The mode state is a small set of single-bit flags. No data is written to them. Each flag owns two adjacent addresses in a 32-byte control window: a write to the odd address sets the flag and a write to the even address clears it. The flags set four things:

- the RAM size, which decides how the low region mirrors;
- whether the map is all RAM or a mix of ROM and RAM;
- which half of RAM appears in the low 32K window;
- the CPU rate.

The same flags mask and offset an incoming video address counter, so the display fetches come from the RAM the CPU sees.

All outputs are registered. The result for an access appears on the clock edge after the access is presented. A flag write takes effect for the next access. The speed and video outputs show the new flag value two edges after the write.

Top module: `mmap_ctrl`

## Requirements
- R1: After reset all flags are 0. The RAM size is therefore 4K, `fast_clk` is 0, and `vid_addr` is `vid_count & 0x0FFF`.
- R2: A write with `cpu_valid` high to an address in 0xFFC0..0xFFDF updates one flag and asserts `ctl_hit`. Address bits [4:1] pick the flag and bit 0 gives its new value (odd sets, even clears). The flag indices are:
  - P1 (page) = 10, at 0xFFD4/0xFFD5
  - R0 = 11, at 0xFFD6/0xFFD7
  - R1 = 12, at 0xFFD8/0xFFD9
  - M0 = 13, at 0xFFDA/0xFFDB
  - M1 = 14, at 0xFFDC/0xFFDD
  - TY (map type) = 15, at 0xFFDE/0xFFDF

  A read in the window asserts `ctl_hit` but changes no flag. For a window access, `bank_sel` and `tgt_addr` are 0.
- R3: The fixed regions select these banks, and `tgt_addr` is the address minus the region start:

  | Address range | Bank |
  |---|---|
  | 0x8000..0x9FFF | 1 |
  | 0xA000..0xBFFF | 2 |
  | 0xC000..0xFEFF | 3 |
  | 0xFF00..0xFF1F | 4 |
  | 0xFF20..0xFF3F | 5 |
  | 0xFF40..0xFF5F | 6 |
  | 0xFF60..0xFFBF | 7 |

  The low region 0x0000..0x7FFF selects bank 0.
- R4: In every mode, 0xFFE0..0xFFFF selects bank 2 with `tgt_addr` = 0x1FE0 OR the low 5 address bits.
- R5: With {M1,M0} = 00 the low region offset is the address AND 0x0FFF. With {M1,M0} = 01 it is the address AND 0x3FFF, so the RAM mirrors.
- R6: With M1 = 1 and TY = 1, every address below 0xFF00 selects bank 0, and `tgt_addr` equals the CPU address.
- R7: With M1 = 1 and TY = 0, the low region selects bank 0 with `tgt_addr` = {P1, addr[14:0]}. Addresses 0x8000..0xFEFF use banks 1..3 as in R3.
- R8: `vid_addr` = (`vid_count` AND mask) OR base, with mask and base set by the mode:

  | Mode | Mask | Base |
  |---|---|---|
  | {M1,M0} = 00 | 0x0FFF | 0 |
  | {M1,M0} = 01 | 0x3FFF | 0 |
  | M1 = 1, TY = 0 | 0x7FFF | P1 × 0x8000 |
  | M1 = 1, TY = 1 | 0xFFFF | 0 |
- R9: `wr_block` is 1 exactly for valid writes whose selected bank is marked read-only in `RO_BANKS` (default banks 1, 2 and 3).
- R10: `fast_clk` = R1 OR R0.
- R11: {M1,M0} = 11 behaves exactly like 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | CPU access this cycle |
| cpu_we | input | 1 | Access is a write |
| cpu_addr | input | 16 | CPU address |
| vid_count | input | 16 | Raw video address counter |
| bank_sel | output | 3 | Selected bank, registered |
| tgt_addr | output | 16 | Offset inside the selected bank, registered |
| wr_block | output | 1 | Write must not reach the bank |
| ctl_hit | output | 1 | Access claimed by the control window |
| fast_clk | output | 1 | Doubled CPU rate selected |
| vid_addr | output | 16 | Masked and based video address |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a 6-flag register and read-only banks 1 to 3. With these values every mode is reachable with a few flag writes. The bench walks through all four size codes and both map types, and toggles the page flag and both speed flags. In each of these states it probes the region edges, the fixed top vector and the read-only write paths.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  localparam int AW     = 16;
  localparam int BW     = 3;
  localparam int NFLAG  = 6;
  localparam int IDX_W  = 4;

  // flag slots inside the local vector
  localparam int F_P1 = 0;
  localparam int F_R0 = 1;
  localparam int F_R1 = 2;
  localparam int F_M0 = 3;
  localparam int F_M1 = 4;
  localparam int F_TY = 5;

  // control-window index (addr[4:1]) owned by each slot
  localparam logic [IDX_W-1:0] SLOT_IDX [NFLAG] = '{4'd10, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15};

  localparam logic [10:0] CTL_PAGE = 11'h7FE;  // 0xFFC0..0xFFDF
  localparam logic [10:0] VEC_PAGE = 11'h7FF;  // 0xFFE0..0xFFFF
  localparam logic [AW-1:0] VEC_OFFS = 16'h1FE0;
  localparam logic [AW-1:0] IO7_BASE = 16'hFF60;

  typedef enum logic [1:0] {SZ_4K = 2'b00, SZ_16K = 2'b01, SZ_64K = 2'b10, SZ_64K_ALT = 2'b11} size_e;

  typedef struct packed {
    logic [BW-1:0] bank;
    logic [AW-1:0] offs;
    logic          ctl;
  } route_t;
endpackage

// File: rtl/mmap_flags.sv
module mmap_flags
  import mmap_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [IDX_W-1:0] idx,
  input  logic             val,
  output logic [NFLAG-1:0] flags
);
  for (genvar g = 0; g < NFLAG; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                             flags[g] <= 1'b0;
      else if (upd && idx == SLOT_IDX[g])  flags[g] <= val;
    end
  end
endmodule

// File: rtl/mmap_route.sv
module mmap_route
  import mmap_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic          m0,
  input  logic          m1,
  input  logic          ty,
  input  logic          p1,
  output route_t        rt
);
  logic          all_ram;
  logic [AW-1:0] ram_off;
  size_e         sz;

  assign sz      = size_e'({m1, m0});
  assign all_ram = m1 && ty;

  always_comb begin
    unique case (sz)
      SZ_4K:   ram_off = addr & 16'h0FFF;
      SZ_16K:  ram_off = addr & 16'h3FFF;
      default: ram_off = ty ? addr : {p1, addr[14:0]};
    endcase
  end

  always_comb begin
    rt = '0;
    if (addr[15:5] == CTL_PAGE) begin
      rt.ctl = 1'b1;
    end else if (addr[15:5] == VEC_PAGE) begin
      rt.bank = 3'd2;
      rt.offs = VEC_OFFS | {11'b0, addr[4:0]};
    end else if (addr[15:8] == 8'hFF) begin
      unique case (addr[7:5])
        3'd0:    begin rt.bank = 3'd4; rt.offs = {11'b0, addr[4:0]}; end
        3'd1:    begin rt.bank = 3'd5; rt.offs = {11'b0, addr[4:0]}; end
        3'd2:    begin rt.bank = 3'd6; rt.offs = {11'b0, addr[4:0]}; end
        default: begin rt.bank = 3'd7; rt.offs = addr - IO7_BASE;    end
      endcase
    end else if (!addr[15] || all_ram) begin
      rt.bank = 3'd0;
      rt.offs = ram_off;
    end else begin
      unique case (addr[14:13])
        2'b00:   begin rt.bank = 3'd1; rt.offs = {3'b0, addr[12:0]}; end
        2'b01:   begin rt.bank = 3'd2; rt.offs = {3'b0, addr[12:0]}; end
        default: begin rt.bank = 3'd3; rt.offs = {2'b0, addr[13:0]}; end
      endcase
    end
  end
endmodule

// File: rtl/mmap_vid.sv
module mmap_vid
  import mmap_pkg::*;
(
  input  logic [AW-1:0] cnt,
  input  logic          m0,
  input  logic          m1,
  input  logic          ty,
  input  logic          p1,
  output logic [AW-1:0] vaddr
);
  logic [AW-1:0] mask, base;

  always_comb begin
    base = '0;
    unique case (size_e'({m1, m0}))
      SZ_4K:   mask = 16'h0FFF;
      SZ_16K:  mask = 16'h3FFF;
      default: begin
        mask = ty ? 16'hFFFF : 16'h7FFF;
        base = (!ty && p1) ? 16'h8000 : 16'h0000;
      end
    endcase
  end

  assign vaddr = (cnt & mask) | base;
endmodule

// File: rtl/mmap_ctrl.sv
module mmap_ctrl
  import mmap_pkg::*;
#(
  parameter logic [7:0] RO_BANKS = 8'b0000_1110
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_valid,
  input  logic          cpu_we,
  input  logic [15:0]   cpu_addr,
  input  logic [15:0]   vid_count,
  output logic [2:0]    bank_sel,
  output logic [15:0]   tgt_addr,
  output logic          wr_block,
  output logic          ctl_hit,
  output logic          fast_clk,
  output logic [15:0]   vid_addr
);
  logic [NFLAG-1:0] fl;
  logic             fl_upd;
  route_t           rt;
  logic [AW-1:0]    vnext;

  assign fl_upd = cpu_valid && cpu_we && (cpu_addr[15:5] == CTL_PAGE);

  mmap_flags u_flags (
    .clk   (clk),
    .rst   (rst),
    .upd   (fl_upd),
    .idx   (cpu_addr[4:1]),
    .val   (cpu_addr[0]),
    .flags (fl)
  );

  mmap_route u_route (
    .addr (cpu_addr),
    .m0   (fl[F_M0]),
    .m1   (fl[F_M1]),
    .ty   (fl[F_TY]),
    .p1   (fl[F_P1]),
    .rt   (rt)
  );

  mmap_vid u_vid (
    .cnt   (vid_count),
    .m0    (fl[F_M0]),
    .m1    (fl[F_M1]),
    .ty    (fl[F_TY]),
    .p1    (fl[F_P1]),
    .vaddr (vnext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_sel <= '0;
      tgt_addr <= '0;
      wr_block <= 1'b0;
      ctl_hit  <= 1'b0;
      fast_clk <= 1'b0;
      vid_addr <= '0;
    end else begin
      bank_sel <= rt.bank;
      tgt_addr <= rt.offs;
      wr_block <= cpu_valid && cpu_we && !rt.ctl && RO_BANKS[rt.bank];
      ctl_hit  <= cpu_valid && rt.ctl;
      fast_clk <= fl[F_R1] | fl[F_R0];
      vid_addr <= vnext;
    end
  end
endmodule

// File: rtl/mmap_ctrl_chk.sv
module mmap_ctrl_chk #(
  parameter logic [7:0] RO_BANKS = 8'b0000_1110
) (
  input logic        clk,
  input logic        rst,
  input logic        cpu_valid,
  input logic        cpu_we,
  input logic [15:0] cpu_addr,
  input logic [2:0]  bank_sel,
  input logic [15:0] tgt_addr,
  input logic        wr_block,
  input logic        ctl_hit,
  input logic        fast_clk
);
  // R9
  ro_target_chk: assert property (@(posedge clk) disable iff (rst)
    wr_block |-> RO_BANKS[bank_sel]);

  // R9
  wr_origin_chk: assert property (@(posedge clk) disable iff (rst)
    wr_block |-> $past(cpu_valid && cpu_we));

  // R4
  top_vector_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cpu_addr[15:5]) == 11'h7FF) |-> (bank_sel == 3'd2 && tgt_addr == {11'h0FF, $past(cpu_addr[4:0])}));

  // R2
  ctl_claim_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_hit |-> ($past(cpu_valid) && $past(cpu_addr[15:5]) == 11'h7FE));

  // R10
  speed_change_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(fast_clk) |-> $past(ctl_hit));
endmodule

bind mmap_ctrl mmap_ctrl_chk #(.RO_BANKS(RO_BANKS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_valid (cpu_valid),
  .cpu_we    (cpu_we),
  .cpu_addr  (cpu_addr),
  .bank_sel  (bank_sel),
  .tgt_addr  (tgt_addr),
  .wr_block  (wr_block),
  .ctl_hit   (ctl_hit),
  .fast_clk  (fast_clk)
);

// File: tb/tb_mmap_ctrl.sv
module tb_mmap_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_valid = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = 16'h0;
  logic [15:0] vid_count = 16'h0;
  logic [2:0]  bank_sel;
  logic [15:0] tgt_addr;
  logic        wr_block, ctl_hit, fast_clk;
  logic [15:0] vid_addr;

  mmap_ctrl dut (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .vid_count(vid_count), .bank_sel(bank_sel),
    .tgt_addr(tgt_addr), .wr_block(wr_block), .ctl_hit(ctl_hit),
    .fast_clk(fast_clk), .vid_addr(vid_addr)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    int          due;
    logic [2:0]  bank;
    logic [15:0] offs;
    logic        wrb;
    logic        hit;
    string       tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  // model flags, bench-side: P1, R0, R1, M0, M1, TY
  bit p1 = 0, r0 = 0, r1 = 0, m0 = 0, m1 = 0, ty = 0;
  localparam logic [7:0] RO = 8'b0000_1110;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic exp_t model(logic [15:0] a, logic we, string tag);
    exp_t e;
    e.due = cyc + 1; e.tag = tag; e.bank = 0; e.offs = 0; e.hit = 0;
    if (a >= 16'hFFC0 && a <= 16'hFFDF) e.hit = 1;
    else if (a >= 16'hFFE0) begin e.bank = 2; e.offs = 16'h1FE0 | (a & 16'h1F); end
    else if (a >= 16'hFF60) begin e.bank = 7; e.offs = a - 16'hFF60; end
    else if (a >= 16'hFF40) begin e.bank = 6; e.offs = a - 16'hFF40; end
    else if (a >= 16'hFF20) begin e.bank = 5; e.offs = a - 16'hFF20; end
    else if (a >= 16'hFF00) begin e.bank = 4; e.offs = a - 16'hFF00; end
    else if (a < 16'h8000 || (m1 && ty)) begin
      e.bank = 0;
      if (!m1)     e.offs = a & (m0 ? 16'h3FFF : 16'h0FFF);
      else if (ty) e.offs = a;
      else         e.offs = (a & 16'h7FFF) | (p1 ? 16'h8000 : 16'h0);
    end
    else if (a < 16'hA000) begin e.bank = 1; e.offs = a - 16'h8000; end
    else if (a < 16'hC000) begin e.bank = 2; e.offs = a - 16'hA000; end
    else begin e.bank = 3; e.offs = a - 16'hC000; end
    e.wrb = we && !e.hit && RO[e.bank];
    return e;
  endfunction

  task automatic acc(logic [15:0] a, logic we, string tag);
    @(negedge clk);
    cpu_valid = 1; cpu_we = we; cpu_addr = a;
    q.push_back(model(a, we, tag));
    if (we && a >= 16'hFFC0 && a <= 16'hFFDF)
      case (a[4:1])
        4'd10: p1 = a[0];
        4'd11: r0 = a[0];
        4'd12: r1 = a[0];
        4'd13: m0 = a[0];
        4'd14: m1 = a[0];
        4'd15: ty = a[0];
        default: ;
      endcase
  endtask

  task automatic idle();
    @(negedge clk);
    cpu_valid = 0; cpu_we = 0;
  endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // settle after flag writes, then check speed and video against the model
  task automatic side(string tag);
    logic [15:0] vm, vb;
    idle(); idle();
    vb = 0;
    if (!m1)     vm = m0 ? 16'h3FFF : 16'h0FFF;
    else if (ty) vm = 16'hFFFF;
    else begin vm = 16'h7FFF; vb = p1 ? 16'h8000 : 16'h0; end
    chk({tag, " R8 vid"}, vid_addr, (vid_count & vm) | vb);
    chk({tag, " R10 fast"}, {15'b0, fast_clk}, {15'b0, (r1 | r0)});
  endtask

  // monitor: pop and compare registered results
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (bank_sel !== e.bank || tgt_addr !== e.offs || wr_block !== e.wrb || ctl_hit !== e.hit) begin
        n_bad++;
        $display("FAIL %s: actual bank=%0d offs=%h wrb=%b hit=%b expected bank=%0d offs=%h wrb=%b hit=%b",
                 e.tag, bank_sel, tgt_addr, wr_block, ctl_hit, e.bank, e.offs, e.wrb, e.hit);
      end
    end
  end

  initial begin
    vid_count = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    side("R1 reset");
    // R5 4K mirroring, R3 regions
    acc(16'h1234, 0, "R5 4K low");
    acc(16'h7ABC, 0, "R5 4K mirror");
    acc(16'h8000, 0, "R3 bank1");
    acc(16'hA123, 0, "R3 bank2");
    acc(16'hC000, 0, "R3 bank3 start");
    acc(16'hFEFF, 0, "R3 bank3 end");
    acc(16'hFF00, 0, "R3 bank4");
    acc(16'hFF25, 0, "R3 bank5");
    acc(16'hFF45, 0, "R3 bank6");
    acc(16'hFF70, 0, "R3 bank7");
    acc(16'hFFBF, 0, "R3 bank7 end");
    acc(16'hFFE7, 0, "R4 vector 4K");
    // R9 write inhibit
    acc(16'h8000, 1, "R9 rom write");
    acc(16'h1000, 1, "R9 ram write");
    acc(16'hFF10, 1, "R9 io write");
    // R2 set M0 -> 16K
    acc(16'hFFDB, 1, "R2 set M0");
    acc(16'h5678, 0, "R5 16K mirror");
    side("R5 16K");
    // R2 read of set-M1 address changes nothing
    acc(16'hFFDD, 0, "R2 read no effect");
    acc(16'h5678, 0, "R2 after read still 16K");
    // R11 M=11 acts as 64K ROM/RAM
    acc(16'hFFDD, 1, "R2 set M1");
    acc(16'h5678, 0, "R11 64K alt low");
    acc(16'h9000, 0, "R11 64K alt rom");
    side("R11 alt");
    // R7 M=10, P1 page
    acc(16'hFFDA, 1, "R2 clear M0");
    acc(16'hFFD5, 1, "R2 set P1");
    vid_count = 16'h1234;
    acc(16'h1234, 0, "R7 page high");
    acc(16'hB000, 1, "R7 rom write blocked R9");
    side("R7 page");
    acc(16'hFFD4, 1, "R2 clear P1");
    acc(16'h1234, 0, "R7 page low");
    // R6 all RAM
    acc(16'hFFD5, 1, "R2 set P1 again");
    acc(16'hFFDF, 1, "R2 set TY");
    acc(16'hA123, 1, "R6 all ram write");
    acc(16'hFEFF, 0, "R6 all ram top");
    acc(16'h1234, 0, "R6 direct");
    acc(16'hFFE3, 0, "R4 vector all ram");
    acc(16'hFF50, 0, "R3 io in all ram");
    side("R6 all ram");
    // R10 speed
    acc(16'hFFD7, 1, "R2 set R0");
    side("R10 R0");
    acc(16'hFFD6, 1, "R2 clear R0");
    side("R10 slow");
    acc(16'hFFD9, 1, "R2 set R1");
    side("R10 R1");
    acc(16'hFFDE, 1, "R2 clear TY");
    acc(16'hA123, 0, "R7 rom back");
    side("R7 rom back");
    idle(); idle();
    done = 1;
  end

  initial begin
    wait (done || cyc > 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule